// File: doc/BRIEF.md
# UART Register Front-End with Interrupt Identification

This block is the processor-facing register file of a 16550-compatible serial port. It decodes 32-bit word-aligned reads and writes on a small register map. It holds the configuration registers: interrupt enable, line control, modem control, scratch, divisor, divisor fraction and halt. It assembles line status from the receiver and transmitter state it is given. It also names the most urgent pending interrupt with a 4-bit identity code and drives a single interrupt line.

The receive and transmit FIFOs, the shift engine and the baud generator live outside. On the receive side, `rx_valid` from the FIFO is the valid and `rx_pop` is this block's ready. `rx_pop` pulses for one cycle only when a data read meets `rx_valid` high, and the byte is taken in that cycle. On the transmit side, `tx_valid` with `tx_data` is a one-cycle push that is only raised while `tx_ready` is high. A data write made while `tx_ready` is low is discarded rather than held, so software must poll line status before writing.

Bus access is a single-cycle strobe. `bus_wr` and `bus_rd` are never high together. Read data is combinational in the strobe cycle. Read side effects and writes take effect at the clock edge that ends the strobe. Address bits 1:0 are ignored.

Top module: `uart_reg_frontend`

## Requirements
- R1: After reset the identity register reads 0x01, line control and interrupt enable read 0, and `irq` is low.
- R2: With line-control bit 7 clear, a read of offset 0x00 returns `rx_data` and pulses `rx_pop` only when `rx_valid` is high, and offset 0x04 is interrupt enable (bits 0,1,2,3,7 writable). With bit 7 set, offsets 0x00 and 0x04 are the divisor low and high bytes, driven on `divisor`, and a read of 0x00 never pops. The divisor changes only on a write.
- R3: A write to offset 0x00 with line-control bit 7 clear pulses `tx_valid` with `tx_data` = write bits 7:0 when `tx_ready` is high, and is discarded with no pulse when `tx_ready` is low.
- R4: Line status at 0x14 has bit0 = `rx_valid`, bits 1..4 = sticky overrun, parity, framing and break flags, bit5 = transmit holding empty, bit6 = `tx_empty` AND `tx_idle`, and bit7 = `rx_fifo_err`. Reading it clears the four sticky flags.
- R5: Identity bits 3:0 at 0x08 report only the highest pending source, in this order. Line error (enable bit2, any sticky flag) gives 6. Character timeout (enable bit0, `rx_timeout`) gives 0xC. Receive data (enable bit0, `rx_valid`) gives 4. Transmit empty (enable bit1) gives 2. Modem change (enable bit3, `modem_delta`) gives 0. Busy detect gives 7. No source gives 1.
- R6: The transmit-empty source is set when `tx_empty` rises, or when enable bit1 is written from 0 to 1 while `tx_empty` is high. It is cleared by an identity read that reports code 2, or by a transmit write.
- R7: A line-control write while `eng_busy` is high and halt bit1 is clear leaves line control unchanged and raises busy detect, which needs no enable. A read of 0x7C clears it. With halt bit1 set, the write takes effect and no busy detect is raised.
- R8: With enable bit7 set, line-status bit5 reports the transmit FIFO as full (NOT `tx_ready`) instead of `tx_empty`.
- R9: Identity bits 7:6 both read as the FIFO enable, which is write bit0 of offset 0x08 and is driven on `fifo_en`.
- R10: 0x10 modem control, 0x1C scratch, 0xA4 halt (3 bits) and 0xC0 divisor fraction (FRAC_W bits) read back what was written. 0x18 reads `modem_in`. 0x7C reads {`rx_valid`, `tx_empty`, `tx_ready`, `eng_busy`} in bits 3:0. 0x80 and 0x84 read `tx_level` and `rx_level`. Unmapped offsets read 0.
- R11: `irq` is high exactly when the identity code is not 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data |
| rx_valid | input | 1 | Receive FIFO not empty |
| rx_data | input | 8 | Receive FIFO head byte |
| rx_pop | output | 1 | Receive FIFO pop |
| tx_valid | output | 1 | Transmit FIFO push |
| tx_data | output | 8 | Byte pushed |
| tx_ready | input | 1 | Transmit FIFO has space |
| err_overrun | input | 1 | Overrun event pulse |
| err_parity | input | 1 | Parity error pulse |
| err_frame | input | 1 | Framing error pulse |
| err_break | input | 1 | Break detected pulse |
| rx_fifo_err | input | 1 | Error byte held in receive FIFO |
| rx_timeout | input | 1 | Character timeout pending |
| tx_empty | input | 1 | Transmit FIFO empty |
| tx_idle | input | 1 | Shift engine idle |
| eng_busy | input | 1 | Serial engine busy |
| modem_in | input | 8 | Modem status value |
| modem_delta | input | 1 | Modem status changed |
| tx_level | input | LVL_W | Transmit FIFO fill |
| rx_level | input | LVL_W | Receive FIFO fill |
| line_cfg | output | 8 | Line control register |
| modem_cfg | output | 8 | Modem control register |
| divisor | output | 16 | Baud divisor |
| div_frac | output | FRAC_W | Divisor fraction |
| fifo_en | output | 1 | FIFO enable |
| halt_cfg | output | 3 | Halt register |
| irq | output | 1 | Interrupt request |

## Verification
The assertions take the receive and transmit side inputs as honest. `rx_pop` may only be seen with `rx_valid` high, and a push only with `tx_ready` high. Error inputs are taken as one-cycle events, and the two bus strobes are never raised in the same cycle. The bench drives every access through one task that raises exactly one strobe for one cycle, and it pulses each error input for a single cycle. During the random priority sweep it holds `tx_empty` low so the transmit-empty source stays quiet, and it draws the remaining sources and enable bits freely.

// File: rtl/uart_rf_pkg.sv
package uart_rf_pkg;
  localparam int ADDR_W   = 8;
  localparam int NUM_REGS = 13;

  // register slot indices
  localparam int RI_DATA  = 0;
  localparam int RI_IER   = 1;
  localparam int RI_IID   = 2;
  localparam int RI_LCR   = 3;
  localparam int RI_MCR   = 4;
  localparam int RI_LSR   = 5;
  localparam int RI_MSR   = 6;
  localparam int RI_SCR   = 7;
  localparam int RI_XSTAT = 8;
  localparam int RI_TXLVL = 9;
  localparam int RI_RXLVL = 10;
  localparam int RI_HALT  = 11;
  localparam int RI_FRAC  = 12;

  localparam logic [7:0] REG_OFS [NUM_REGS] = '{
    8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h18,
    8'h1C, 8'h7C, 8'h80, 8'h84, 8'hA4, 8'hC0};

  localparam logic [7:0] IER_MASK = 8'h8F;

  typedef enum logic [3:0] {
    IID_MODEM   = 4'h0,
    IID_NONE    = 4'h1,
    IID_THRE    = 4'h2,
    IID_RXDATA  = 4'h4,
    IID_LINE    = 4'h6,
    IID_BUSY    = 4'h7,
    IID_TIMEOUT = 4'hC
  } iid_e;
endpackage

// File: rtl/uart_rf_decode.sv
module uart_rf_decode
  import uart_rf_pkg::*;
(
  input  logic [ADDR_W-3:0]   word_addr,
  output logic [NUM_REGS-1:0] hit
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_slot
    assign hit[g] = (word_addr == REG_OFS[g][ADDR_W-1:2]);
  end
endmodule

// File: rtl/uart_rf_lsr.sv
module uart_rf_lsr #(
  parameter int NERR = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NERR-1:0] err_in,
  input  logic            clr,
  output logic [NERR-1:0] err_q
);
  // a new event in the clearing cycle survives the clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= '0;
    else        err_q <= (clr ? '0 : err_q) | err_in;
  end
endmodule

// File: rtl/uart_rf_irq.sv
module uart_rf_irq
  import uart_rf_pkg::*;
(
  input  logic [3:0] ier,
  input  logic       line_pend,
  input  logic       rx_valid,
  input  logic       rx_timeout,
  input  logic       thre_pend,
  input  logic       modem_delta,
  input  logic       busy_pend,
  output iid_e       iid,
  output logic       irq
);
  // lowest priority first, later assignments override
  always_comb begin
    iid = IID_NONE;
    if (busy_pend)                 iid = IID_BUSY;
    if (ier[3] && modem_delta)     iid = IID_MODEM;
    if (ier[1] && thre_pend)       iid = IID_THRE;
    if (ier[0] && rx_valid)        iid = IID_RXDATA;
    if (ier[0] && rx_timeout)      iid = IID_TIMEOUT;
    if (ier[2] && line_pend)       iid = IID_LINE;
  end
  assign irq = (iid != IID_NONE);
endmodule

// File: rtl/uart_reg_frontend.sv
module uart_reg_frontend
  import uart_rf_pkg::*;
#(
  parameter int LVL_W  = 6,
  parameter int FRAC_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  output logic              rx_pop,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  input  logic              tx_ready,
  input  logic              err_overrun,
  input  logic              err_parity,
  input  logic              err_frame,
  input  logic              err_break,
  input  logic              rx_fifo_err,
  input  logic              rx_timeout,
  input  logic              tx_empty,
  input  logic              tx_idle,
  input  logic              eng_busy,
  input  logic [7:0]        modem_in,
  input  logic              modem_delta,
  input  logic [LVL_W-1:0]  tx_level,
  input  logic [LVL_W-1:0]  rx_level,
  output logic [7:0]        line_cfg,
  output logic [7:0]        modem_cfg,
  output logic [15:0]       divisor,
  output logic [FRAC_W-1:0] div_frac,
  output logic              fifo_en,
  output logic [2:0]        halt_cfg,
  output logic              irq
);
  localparam int LVL_PAD  = 32 - LVL_W;
  localparam int FRAC_PAD = 32 - FRAC_W;

  logic [NUM_REGS-1:0] hit;
  logic [7:0] ier_q, scratch_q, lsr_v;
  logic [3:0] err_q;
  logic       dlab, thre_q, busy_q, empty_d;
  logic       thr_wr, lcr_blocked, thre_set, thre_clr, busy_clr;
  iid_e       iid;
  logic       unused_bits;

  assign unused_bits = ^{bus_addr[1:0], bus_wdata[31:8]};
  assign dlab        = line_cfg[7];

  uart_rf_decode i_decode (
    .word_addr (bus_addr[ADDR_W-1:2]),
    .hit       (hit)
  );

  uart_rf_lsr #(.NERR(4)) i_lsr (
    .clk    (clk),
    .rst_n  (rst_n),
    .err_in ({err_break, err_frame, err_parity, err_overrun}),
    .clr    (bus_rd && hit[RI_LSR]),
    .err_q  (err_q)
  );

  uart_rf_irq i_irq (
    .ier         (ier_q[3:0]),
    .line_pend   (|err_q),
    .rx_valid    (rx_valid),
    .rx_timeout  (rx_timeout),
    .thre_pend   (thre_q),
    .modem_delta (modem_delta),
    .busy_pend   (busy_q),
    .iid         (iid),
    .irq         (irq)
  );

  // data port side
  assign thr_wr   = bus_wr && hit[RI_DATA] && !dlab;
  assign tx_valid = thr_wr && tx_ready;
  assign tx_data  = bus_wdata[7:0];
  assign rx_pop   = bus_rd && hit[RI_DATA] && !dlab && rx_valid;

  assign lcr_blocked = bus_wr && hit[RI_LCR] && eng_busy && !halt_cfg[1];

  // configuration registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_cfg  <= '0;
      modem_cfg <= '0;
      divisor   <= '0;
      div_frac  <= '0;
      fifo_en   <= 1'b0;
      halt_cfg  <= '0;
      ier_q     <= '0;
      scratch_q <= '0;
    end else if (bus_wr) begin
      if (hit[RI_DATA] && dlab) divisor[7:0] <= bus_wdata[7:0];
      if (hit[RI_IER]) begin
        if (dlab) divisor[15:8] <= bus_wdata[7:0];
        else      ier_q         <= bus_wdata[7:0] & IER_MASK;
      end
      if (hit[RI_IID])                  fifo_en   <= bus_wdata[0];
      if (hit[RI_LCR] && !lcr_blocked)  line_cfg  <= bus_wdata[7:0];
      if (hit[RI_MCR])                  modem_cfg <= bus_wdata[7:0];
      if (hit[RI_SCR])                  scratch_q <= bus_wdata[7:0];
      if (hit[RI_HALT])                 halt_cfg  <= bus_wdata[2:0];
      if (hit[RI_FRAC])                 div_frac  <= bus_wdata[FRAC_W-1:0];
    end
  end

  // pending-source flags
  assign thre_set = (tx_empty && !empty_d) ||
                    (bus_wr && hit[RI_IER] && !dlab && bus_wdata[1] && !ier_q[1] && tx_empty);
  assign thre_clr = thr_wr || (bus_rd && hit[RI_IID] && iid == IID_THRE);
  assign busy_clr = bus_rd && hit[RI_XSTAT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      empty_d <= 1'b1;
      thre_q  <= 1'b0;
      busy_q  <= 1'b0;
    end else begin
      empty_d <= tx_empty;
      thre_q  <= thre_set || (thre_q && !thre_clr);
      busy_q  <= lcr_blocked || (busy_q && !busy_clr);
    end
  end

  assign lsr_v = {rx_fifo_err, tx_empty && tx_idle,
                  ier_q[7] ? !tx_ready : tx_empty, err_q, rx_valid};

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (hit[RI_DATA])  bus_rdata = {24'h0, dlab ? divisor[7:0] : rx_data};
      if (hit[RI_IER])   bus_rdata = {24'h0, dlab ? divisor[15:8] : ier_q};
      if (hit[RI_IID])   bus_rdata = {24'h0, fifo_en, fifo_en, 2'b00, iid};
      if (hit[RI_LCR])   bus_rdata = {24'h0, line_cfg};
      if (hit[RI_MCR])   bus_rdata = {24'h0, modem_cfg};
      if (hit[RI_LSR])   bus_rdata = {24'h0, lsr_v};
      if (hit[RI_MSR])   bus_rdata = {24'h0, modem_in};
      if (hit[RI_SCR])   bus_rdata = {24'h0, scratch_q};
      if (hit[RI_XSTAT]) bus_rdata = {28'h0, rx_valid, tx_empty, tx_ready, eng_busy};
      if (hit[RI_TXLVL]) bus_rdata = {{LVL_PAD{1'b0}}, tx_level};
      if (hit[RI_RXLVL]) bus_rdata = {{LVL_PAD{1'b0}}, rx_level};
      if (hit[RI_HALT])  bus_rdata = {29'h0, halt_cfg};
      if (hit[RI_FRAC])  bus_rdata = {{FRAC_PAD{1'b0}}, div_frac};
    end
  end
endmodule

// File: rtl/uart_reg_frontend_chk.sv
module uart_reg_frontend_chk
  import uart_rf_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              rx_pop,
  input logic              rx_valid,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic              eng_busy,
  input logic [2:0]        halt_cfg,
  input logic [7:0]        line_cfg,
  input logic [15:0]       divisor,
  input logic [3:0]        err_q,
  input logic              err_any_in,
  input logic [3:0]        ier_lo,
  input logic              busy_q,
  input logic              irq
);
  logic lcr_busy_wr;
  assign lcr_busy_wr = bus_wr && bus_addr[7:2] == REG_OFS[RI_LCR][7:2] && eng_busy && !halt_cfg[1];

  p_pop_needs_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop |-> rx_valid);

  p_div_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> $stable(divisor));

  p_push_needs_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> tx_ready);

  p_lsr_read_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr[7:2] == REG_OFS[RI_LSR][7:2] && !err_any_in) |=> (err_q == 4'h0));

  p_lcr_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lcr_busy_wr |=> $stable(line_cfg));

  p_busy_raises_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lcr_busy_wr |=> irq);

  p_quiet_when_masked_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ier_lo == 4'h0 && !busy_q) |-> !irq);
endmodule

bind uart_reg_frontend uart_reg_frontend_chk i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_wr     (bus_wr),
  .bus_rd     (bus_rd),
  .bus_addr   (bus_addr),
  .rx_pop     (rx_pop),
  .rx_valid   (rx_valid),
  .tx_valid   (tx_valid),
  .tx_ready   (tx_ready),
  .eng_busy   (eng_busy),
  .halt_cfg   (halt_cfg),
  .line_cfg   (line_cfg),
  .divisor    (divisor),
  .err_q      (err_q),
  .err_any_in (err_overrun | err_parity | err_frame | err_break),
  .ier_lo     (ier_q[3:0]),
  .busy_q     (busy_q),
  .irq        (irq)
);

// File: tb/test_uart_reg_frontend.sv
module test_uart_reg_frontend;
  localparam int LVL_W  = 6;
  localparam int FRAC_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic rx_valid = 1'b0;
  logic [7:0] rx_data = '0;
  logic rx_pop, tx_valid;
  logic [7:0] tx_data;
  logic tx_ready = 1'b1;
  logic err_overrun = 1'b0, err_parity = 1'b0, err_frame = 1'b0, err_break = 1'b0;
  logic rx_fifo_err = 1'b0, rx_timeout = 1'b0;
  logic tx_empty = 1'b1, tx_idle = 1'b1, eng_busy = 1'b0;
  logic [7:0] modem_in = '0;
  logic modem_delta = 1'b0;
  logic [LVL_W-1:0] tx_level = '0, rx_level = '0;
  logic [7:0] line_cfg, modem_cfg;
  logic [15:0] divisor;
  logic [FRAC_W-1:0] div_frac;
  logic fifo_en;
  logic [2:0] halt_cfg;
  logic irq;

  int n_checks = 0;
  int n_errs = 0;
  logic [31:0] q;
  logic pop_s, push_s;
  logic [7:0] pdata_s;

  always #10 clk = ~clk;

  uart_reg_frontend #(.LVL_W(LVL_W), .FRAC_W(FRAC_W)) i_uart_reg_frontend (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic acc(input logic w, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = w; bus_rd = !w; bus_addr = a; bus_wdata = d;
    #5;
    q = bus_rdata; pop_s = rx_pop; push_s = tx_valid; pdata_s = tx_data;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    acc(1'b1, a, d);
  endtask

  task automatic rd(input logic [7:0] a);
    acc(1'b0, a, 32'h0);
  endtask

  function automatic logic [3:0] exp_iid(input logic [7:0] ie, input logic err, input logic rxv,
                                         input logic tmo, input logic thre, input logic md,
                                         input logic busy);
    if (ie[2] && err)  return 4'h6;
    if (ie[0] && tmo)  return 4'hC;
    if (ie[0] && rxv)  return 4'h4;
    if (ie[1] && thre) return 4'h2;
    if (ie[3] && md)   return 4'h0;
    if (busy)          return 4'h7;
    return 4'h1;
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    n_checks++; n_errs++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'h5EED1234);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 irq after reset", irq, 0);
    chk("R11 irq idle", irq, 0);
    rd(8'h08); chk("R1 iid reset", q, 32'h01);
    rd(8'h0C); chk("R1 lcr reset", q, 32'h00);
    rd(8'h04); chk("R1 ier reset", q, 32'h00);
    rd(8'h14); chk("R4 lsr idle", q, 32'h60);

    // R9 fifo enable flags
    wr(8'h08, 32'h1);
    chk("R9 fifo_en pin", fifo_en, 1);
    rd(8'h08); chk("R9 iid flags", q, 32'hC1);

    // R2 divisor access
    rx_valid = 1'b1; rx_data = 8'hA5;
    wr(8'h0C, 32'h83);
    wr(8'h00, 32'h1B);
    wr(8'h04, 32'h01);
    chk("R2 divisor", divisor, 16'h011B);
    rd(8'h00); chk("R2 dll read", q, 32'h1B); chk("R2 no pop under dlab", pop_s, 0);
    rd(8'h04); chk("R2 dlh read", q, 32'h01);
    wr(8'h0C, 32'h03);
    rd(8'h00); chk("R2 rbr read", q, 32'hA5); chk("R2 pop", pop_s, 1);
    rd(8'h04); chk("R2 ier back", q, 32'h00);
    rx_valid = 1'b0;
    rd(8'h00); chk("R2 no pop when empty", pop_s, 0);
    chk("R2 divisor kept", divisor, 16'h011B);

    // R3 transmit push
    wr(8'h00, 32'h15A);
    chk("R3 push", push_s, 1); chk("R3 push data", pdata_s, 8'h5A);
    tx_ready = 1'b0;
    wr(8'h00, 32'h33);
    chk("R3 drop when full", push_s, 0);
    tx_ready = 1'b1;

    // R6 transmit-empty source
    wr(8'h04, 32'h02);
    chk("R11 irq thre", irq, 1);
    rd(8'h08); chk("R6 iid thre", q, 32'hC2);
    rd(8'h08); chk("R6 cleared by iid read", q, 32'hC1);
    chk("R11 irq cleared", irq, 0);
    @(negedge clk) tx_empty = 1'b0;
    @(negedge clk) tx_empty = 1'b1;
    @(negedge clk);
    chk("R6 set on rise", irq, 1);
    wr(8'h00, 32'h11);
    chk("R6 cleared by thr write", irq, 0);
    rd(8'h08); chk("R6 iid after thr write", q, 32'hC1);
    wr(8'h04, 32'h00);

    // R4 sticky errors
    @(negedge clk) err_parity = 1'b1;
    @(negedge clk) err_parity = 1'b0;
    rd(8'h14); chk("R4 parity bit", q, 32'h64);
    rd(8'h14); chk("R4 cleared", q, 32'h60);
    @(negedge clk) begin err_break = 1'b1; err_overrun = 1'b1; end
    @(negedge clk) begin err_break = 1'b0; err_overrun = 1'b0; end
    rd(8'h14); chk("R4 break+overrun", q, 32'h72);
    rd(8'h14); chk("R4 cleared again", q, 32'h60);
    rx_fifo_err = 1'b1;
    rd(8'h14); chk("R4 fifo error bit", q, 32'hE0);
    rx_fifo_err = 1'b0;

    // R7 busy detect
    eng_busy = 1'b1;
    wr(8'h0C, 32'h1F);
    rd(8'h0C); chk("R7 lcr locked", q, 32'h03);
    chk("R7 irq busy", irq, 1);
    rd(8'h08); chk("R7 iid busy", q, 32'hC7);
    rd(8'h7C); chk("R10 xstat", q, 32'h7);
    rd(8'h08); chk("R7 busy cleared", q, 32'hC1);
    wr(8'hA4, 32'h2);
    wr(8'h0C, 32'h1B);
    rd(8'h0C); chk("R7 forced lcr write", q, 32'h1B);
    rd(8'h08); chk("R7 no busy when forced", q, 32'hC1);
    rd(8'hA4); chk("R10 halt read", q, 32'h2);
    wr(8'hA4, 32'h0);
    eng_busy = 1'b0;
    wr(8'h0C, 32'h03);

    // R8 programmable empty mode
    wr(8'h04, 32'h80);
    rd(8'h14); chk("R8 not full", q, 32'h40);
    tx_ready = 1'b0;
    rd(8'h14); chk("R8 full", q, 32'h60);
    tx_ready = 1'b1;
    wr(8'h04, 32'h00);

    // R10 random register traffic
    for (int i = 0; i < 8; i++) begin
      logic [7:0] v;
      v = 8'($urandom);
      wr(8'h1C, {24'h0, v}); rd(8'h1C); chk("R10 scratch", q, {24'h0, v});
      wr(8'h10, {24'h0, ~v}); rd(8'h10); chk("R10 mcr", q, {24'h0, ~v});
      wr(8'hC0, {24'h0, v}); rd(8'hC0); chk("R10 frac", q, {28'h0, v[3:0]});
      modem_in = 8'($urandom); tx_level = 6'($urandom); rx_level = 6'($urandom);
      rd(8'h18); chk("R10 msr", q, {24'h0, modem_in});
      rd(8'h80); chk("R10 tx level", q, {26'h0, tx_level});
      rd(8'h84); chk("R10 rx level", q, {26'h0, rx_level});
      rd(8'h20 + 8'(4 * (i % 4))); chk("R10 unmapped", q, 32'h0);
    end

    // R5 random priority sweep, transmit-empty source kept quiet
    tx_empty = 1'b0;
    wr(8'h00, 32'h0);
    for (int i = 0; i < 40; i++) begin
      logic [7:0] ie;
      logic rxv, tmo, md;
      int e;
      ie = 8'($urandom) & 8'h0F;
      rxv = 1'($urandom); tmo = 1'($urandom); md = 1'($urandom);
      e = int'($urandom % 5);
      wr(8'h04, {24'h0, ie});
      @(negedge clk);
      rx_valid = rxv; rx_timeout = tmo; modem_delta = md;
      err_overrun = (e == 1); err_parity = (e == 2); err_frame = (e == 3); err_break = (e == 4);
      @(negedge clk);
      err_overrun = 1'b0; err_parity = 1'b0; err_frame = 1'b0; err_break = 1'b0;
      chk("R11 irq vs sources", irq, exp_iid(ie, e != 0, rxv, tmo, 1'b0, md, 1'b0) != 4'h1);
      rd(8'h08);
      chk("R5 iid priority", q, {24'h0, 4'hC, exp_iid(ie, e != 0, rxv, tmo, 1'b0, md, 1'b0)});
      rd(8'h14);
      chk("R4 lsr random", q, {24'h0, 3'b000, (e == 4), (e == 3), (e == 2), (e == 1), rxv});
      rx_valid = 1'b0; rx_timeout = 1'b0; modem_delta = 1'b0;
    end

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end
endmodule